// File: doc/BRIEF.md
# Flash Write-Enable Handshake Sequencer

This block gets a serial NOR flash ready for a program or erase operation. A requester pulses a start input. The sequencer then sends the write-enable instruction to the flash and reads back one status byte. It keeps repeating that pair until the status byte shows the write-enable latch set. If the status shows the device busy, the sequencer polls the status byte at a fixed interval until the device is idle, and then starts a new attempt.

The sequencer does no serial shifting of its own. It hands whole commands, one at a time, to a flash engine through a byte-level command port. Each command carries an opcode, an address-present flag, a direction and a byte count. The engine answers each command with a completion pulse, an error flag and, for reads, a data byte.

Some devices need one extra flag-status read after every busy period, or they stop responding. A per-chip flag input, sampled at start, turns that read on. The sequencer reports the outcome to the requester with a one-cycle done pulse and a result code.

Top module: `wel_handshake_seq`

## Requirements
- R1: While reset is held, and after it is released, `cmd_valid` and `req_done` are low and `req_code` is 0.
- R2: A start pulse while idle begins an attempt. An attempt is the write-enable command (opcode 0x06, no address, write, length 0), then on the next cycle a status read (opcode 0x05, no address, read, length 1).
- R3: A command stays on the port with all fields stable until the cycle in which `cmd_done` is sampled. The next command, or the drop of `cmd_valid`, follows on the next cycle.
- R4: Status bit 0 is the busy flag and status bit 1 is the write-enable latch. If the status read after write-enable shows bit 1 set and bit 0 clear, the block finishes with code 0.
- R5: If that status read shows neither bit set, a new attempt starts. After MAX_TRIES attempts without success, the block finishes with code 1.
- R6: If bit 0 is set, bit 1 is ignored and the block polls opcode 0x05 until bit 0 clears. The first poll follows at once. Between polls, `cmd_valid` stays low for exactly POLL_GAP cycles. An attempt that ended in such a wait counts toward MAX_TRIES.
- R7: If `req_quirk` was high at start, each wait that ends idle is followed by one flag-status read (opcode 0x70, no address, read, length 1) before the next write-enable.
- R8: If MAX_POLLS polls in one wait all show bit 0 set, the block finishes with code 2.
- R9: If `cmd_err` is high with `cmd_done`, the block finishes at once with code 3 and issues no further command.
- R10: `req_done` is a one-cycle pulse in the cycle after the last `cmd_done` is sampled. `req_code` holds its value until the next finish.
- R11: `req_start` has no effect while a sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start pulse from the requester |
| req_quirk | input | 1 | Per-chip flag enabling the extra flag-status read |
| req_done | output | 1 | One-cycle completion pulse |
| req_code | output | 2 | Result: 0 ok, 1 latch timeout, 2 busy timeout, 3 port error |
| cmd_valid | output | 1 | A command is presented to the engine |
| cmd_op | output | 8 | Command opcode |
| cmd_has_addr | output | 1 | Command carries an address |
| cmd_is_read | output | 1 | Command reads data (1) or writes (0) |
| cmd_len | output | 3 | Data byte count |
| cmd_done | input | 1 | Engine completion pulse |
| cmd_err | input | 1 | Engine error, valid with `cmd_done` |
| cmd_rdata | input | 8 | Read byte, valid with `cmd_done` |

## Verification
The bench models the flash engine. It completes every command one cycle after picking it up and answers status reads from a scripted list. The first command appears in the cycle after the start pulse is sampled. Each following command appears in the cycle after the previous `cmd_done` is sampled, except after a busy poll, where the bench counts the low cycles of `cmd_valid` and expects exactly POLL_GAP of them. `req_done` is checked to come exactly one cycle after the final `cmd_done` and to rise only once. All samples are taken on the falling clock edge, so every register stage is counted and no sample races the design's edge.

// File: rtl/wel_seq_pkg.sv
package wel_seq_pkg;

    localparam int CMD_LEN_W = 3;
    localparam int OP_W      = 8;

    localparam logic [OP_W-1:0] OP_WREN   = 8'h06;
    localparam logic [OP_W-1:0] OP_RDSR   = 8'h05;
    localparam logic [OP_W-1:0] OP_FLAGSR = 8'h70;

    localparam int BIT_BUSY = 0;
    localparam int BIT_WEL  = 1;

    typedef enum logic [2:0] {
        S_IDLE, S_WREN, S_STAT, S_POLL, S_PAUSE, S_FLAG
    } seq_state_t;

    typedef enum logic [1:0] {
        RES_OK           = 2'd0,
        RES_WEL_TIMEOUT  = 2'd1,
        RES_BUSY_TIMEOUT = 2'd2,
        RES_PORT_ERR     = 2'd3
    } result_t;

    typedef struct packed {
        logic                 valid;
        logic [OP_W-1:0]      op;
        logic                 has_addr;
        logic                 is_read;
        logic [CMD_LEN_W-1:0] len;
    } cmd_t;

    // Command presented on the port for each sequencer state.
    function automatic cmd_t cmd_for(seq_state_t s);
        cmd_t c;
        c = '0;
        case (s)
            S_WREN: begin c.valid = 1'b1; c.op = OP_WREN; end
            S_STAT, S_POLL: begin
                c.valid = 1'b1; c.op = OP_RDSR;
                c.is_read = 1'b1; c.len = CMD_LEN_W'(1);
            end
            S_FLAG: begin
                c.valid = 1'b1; c.op = OP_FLAGSR;
                c.is_read = 1'b1; c.len = CMD_LEN_W'(1);
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/wel_limit_ctr.sv
module wel_limit_ctr #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && cnt != LAST)
            cnt <= cnt + W'(1);
    end

    assign at_last = (cnt == LAST);

    AST_CTR_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST); // R5

endmodule

// File: rtl/wel_pause_timer.sv
module wel_pause_timer #(
    parameter int GAP = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(GAP + 1);
    localparam logic [CW-1:0] START = CW'(GAP - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= START;
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/wel_handshake_seq.sv
module wel_handshake_seq
    import wel_seq_pkg::*;
#(
    parameter int MAX_TRIES = 1000,
    parameter int POLL_GAP  = 10000,
    parameter int MAX_POLLS = 100000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_start,
    input  logic                 req_quirk,
    output logic                 req_done,
    output logic [1:0]           req_code,
    output logic                 cmd_valid,
    output logic [OP_W-1:0]      cmd_op,
    output logic                 cmd_has_addr,
    output logic                 cmd_is_read,
    output logic [CMD_LEN_W-1:0] cmd_len,
    input  logic                 cmd_done,
    input  logic                 cmd_err,
    input  logic [OP_W-1:0]      cmd_rdata
);
    seq_state_t state, nxt;
    result_t    code_q, fin_code;
    logic       fin, quirk_q;
    cmd_t       cur;

    logic busy_bit, wel_bit, ok_done;
    logic tries_last, polls_last, gap_over;
    logic attempt_fail, polls_clr, polls_inc;

    assign cur          = cmd_for(state);
    assign cmd_valid    = cur.valid;
    assign cmd_op       = cur.op;
    assign cmd_has_addr = cur.has_addr;
    assign cmd_is_read  = cur.is_read;
    assign cmd_len      = cur.len;

    assign busy_bit = cmd_rdata[BIT_BUSY];
    assign wel_bit  = cmd_rdata[BIT_WEL];
    assign ok_done  = cmd_done && !cmd_err;

    assign attempt_fail = ok_done &&
        ((state == S_STAT && !busy_bit && !wel_bit) ||
         (state == S_POLL && !busy_bit && !quirk_q) ||
         (state == S_FLAG));
    assign polls_clr = (state == S_STAT) && ok_done && busy_bit;
    assign polls_inc = (state == S_POLL) && ok_done && busy_bit;

    wel_limit_ctr #(.LIMIT(MAX_TRIES)) u_tries (
        .clk(clk), .rst(rst),
        .clr(state == S_IDLE), .inc(attempt_fail), .at_last(tries_last)
    );

    wel_limit_ctr #(.LIMIT(MAX_POLLS)) u_polls (
        .clk(clk), .rst(rst),
        .clr(polls_clr), .inc(polls_inc), .at_last(polls_last)
    );

    wel_pause_timer #(.GAP(POLL_GAP)) u_gap (
        .clk(clk), .rst(rst),
        .load(state != S_PAUSE), .expired(gap_over)
    );

    always_comb begin
        nxt      = state;
        fin      = 1'b0;
        fin_code = RES_OK;
        if (cmd_done && cmd_err && state != S_IDLE && state != S_PAUSE) begin
            fin      = 1'b1;
            fin_code = RES_PORT_ERR;
        end else begin
            case (state)
                S_IDLE:  if (req_start) nxt = S_WREN;
                S_WREN:  if (cmd_done) nxt = S_STAT;
                S_STAT: if (cmd_done) begin
                    if (busy_bit)        nxt = S_POLL;
                    else if (wel_bit)    fin = 1'b1;
                    else if (tries_last) begin fin = 1'b1; fin_code = RES_WEL_TIMEOUT; end
                    else                 nxt = S_WREN;
                end
                S_POLL: if (cmd_done) begin
                    if (busy_bit) begin
                        if (polls_last) begin fin = 1'b1; fin_code = RES_BUSY_TIMEOUT; end
                        else            nxt = S_PAUSE;
                    end
                    else if (quirk_q)    nxt = S_FLAG;
                    else if (tries_last) begin fin = 1'b1; fin_code = RES_WEL_TIMEOUT; end
                    else                 nxt = S_WREN;
                end
                S_PAUSE: if (gap_over) nxt = S_POLL;
                S_FLAG: if (cmd_done) begin
                    if (tries_last) begin fin = 1'b1; fin_code = RES_WEL_TIMEOUT; end
                    else            nxt = S_WREN;
                end
                default: nxt = S_IDLE;
            endcase
        end
        if (fin) nxt = S_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            req_done <= 1'b0;
            code_q   <= RES_OK;
            quirk_q  <= 1'b0;
        end else begin
            state    <= nxt;
            req_done <= fin;
            if (fin) code_q <= fin_code;
            if (state == S_IDLE && req_start) quirk_q <= req_quirk;
        end
    end

    assign req_code = code_q;

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_op)); // R3
    AST_DROP_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_valid) |-> $past(cmd_done)); // R3
    AST_WREN_SHAPE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_op == OP_WREN |-> !cmd_is_read && cmd_len == '0 && !cmd_has_addr); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        req_done |=> !req_done); // R10
    AST_DONE_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (rst)
        req_done |-> $past(cmd_done)); // R10

endmodule

// File: tb/wel_handshake_seq_test.sv
module wel_handshake_seq_test;
    localparam int TRIES = 4;
    localparam int GAP   = 3;
    localparam int POLLS = 3;
    localparam int LAT   = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_start = 1'b0, req_quirk = 1'b0;
    logic req_done;
    logic [1:0] req_code;
    logic cmd_valid, cmd_has_addr, cmd_is_read;
    logic [7:0] cmd_op;
    logic [2:0] cmd_len;
    logic cmd_done = 1'b0, cmd_err = 1'b0;
    logic [7:0] cmd_rdata = 8'h00;

    always #5 clk = ~clk;

    wel_handshake_seq #(.MAX_TRIES(TRIES), .POLL_GAP(GAP), .MAX_POLLS(POLLS)) uut (
        .clk(clk), .rst(rst), .req_start(req_start), .req_quirk(req_quirk),
        .req_done(req_done), .req_code(req_code),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_has_addr(cmd_has_addr),
        .cmd_is_read(cmd_is_read), .cmd_len(cmd_len),
        .cmd_done(cmd_done), .cmd_err(cmd_err), .cmd_rdata(cmd_rdata)
    );

    int checks = 0, fails = 0;
    logic [7:0] lg [0:31];
    int gapb [0:31];
    logic [7:0] stat [0:15];
    logic [7:0] eops [0:31];
    int en, n_cmd, sidx, low_run, err_at, fld_bad, timing_bad, done_cnt, wc;
    logic active, pd;
    logic [7:0] cur_op;

    // Engine model and monitor, all on the falling edge.
    always @(negedge clk) begin
        if (rst) begin
            active = 1'b0; cmd_done = 1'b0; cmd_err = 1'b0;
        end else begin
            pd = cmd_done;
            if (req_done) begin
                done_cnt++;
                if (!pd) timing_bad++;
            end
            if (cmd_done) begin cmd_done = 1'b0; cmd_err = 1'b0; active = 1'b0; end
            if (!active && cmd_valid) begin
                if (n_cmd < 32) begin lg[n_cmd] = cmd_op; gapb[n_cmd] = low_run; end
                low_run = 0;
                n_cmd++;
                cur_op = cmd_op;
                active = 1'b1;
                wc = LAT;
                if (cmd_has_addr) fld_bad++;
                if (cmd_op == 8'h06) begin
                    if (cmd_is_read || cmd_len != 3'd0) fld_bad++;
                end else if (cmd_op == 8'h05 || cmd_op == 8'h70) begin
                    if (!cmd_is_read || cmd_len != 3'd1) fld_bad++;
                end else fld_bad++;
            end else if (!cmd_valid) low_run++;
            if (active) begin
                if (!cmd_valid || cmd_op != cur_op) fld_bad++;
                wc--;
                if (wc == 0) begin
                    cmd_done = 1'b1;
                    cmd_err  = (n_cmd - 1 == err_at);
                    if (cur_op == 8'h05) begin
                        cmd_rdata = stat[sidx];
                        if (sidx < 15) sidx++;
                    end else cmd_rdata = 8'h80;
                end
            end
        end
    end

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic prep();
        n_cmd = 0; sidx = 0; low_run = 0; err_at = -1; fld_bad = 0;
        timing_bad = 0; done_cnt = 0; en = 0;
        for (int i = 0; i < 16; i++) stat[i] = 8'h00;
    endtask

    task automatic ep(input logic [7:0] o);
        eops[en] = o; en++;
    endtask

    task automatic go(input logic q, input int restart_at);
        int cyc;
        @(negedge clk);
        req_quirk = q; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        cyc = 0;
        while (done_cnt == 0 && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (cyc == restart_at) req_start = 1'b1;
            else req_start = 1'b0;
        end
        req_start = 1'b0;
        if (cyc >= 3000) chk(1'b0, "watchdog: sequence hung", cyc, 0);
        repeat (6) @(negedge clk);
    endtask

    task automatic verify(input string tag, input int code);
        logic same;
        same = (n_cmd == en);
        for (int i = 0; i < en && i < 32; i++) if (lg[i] != eops[i]) same = 1'b0;
        chk(same, {tag, " opcode sequence"}, n_cmd, en);
        chk(req_code == 2'(code), {tag, " result code"}, req_code, code);
        chk(done_cnt == 1, {tag, " single done pulse"}, done_cnt, 1);
        chk(timing_bad == 0, {tag, " done one cycle after last cmd_done"}, timing_bad, 0);
        chk(fld_bad == 0, {tag, " command fields and hold"}, fld_bad, 0);
    endtask

    initial begin
        #2_000_000;
        fails++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        prep();
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(!cmd_valid && !req_done, "R1 outputs low in reset", cmd_valid, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!cmd_valid, "R1 cmd_valid low after reset", cmd_valid, 0);
        chk(!req_done && req_code == 2'd0, "R1 done/code after reset", req_code, 0);

        // R2 R4: immediate success
        prep(); stat[0] = 8'h02; ep(8'h06); ep(8'h05);
        go(1'b0, 0); verify("R2 R4 immediate", 0);
        chk(gapb[1] == 0, "R2 R3 status read back-to-back", gapb[1], 0);

        // R4 latch on third attempt
        prep(); stat[0] = 8'h00; stat[1] = 8'h00; stat[2] = 8'h02;
        for (int i = 0; i < 3; i++) begin ep(8'h06); ep(8'h05); end
        go(1'b0, 0); verify("R4 third attempt", 0);

        // R5 attempt limit
        prep();
        for (int i = 0; i < TRIES; i++) begin ep(8'h06); ep(8'h05); end
        go(1'b0, 0); verify("R5 latch timeout", 1);
        repeat (5) @(negedge clk);
        chk(req_code == 2'd1, "R10 code held", req_code, 1);

        // R6 busy wait, busy bit beats latch bit
        prep(); stat[0] = 8'h03; stat[1] = 8'h03; stat[2] = 8'h00; stat[3] = 8'h02;
        ep(8'h06); ep(8'h05); ep(8'h05); ep(8'h05); ep(8'h06); ep(8'h05);
        go(1'b0, 0); verify("R6 busy wait", 0);
        chk(gapb[2] == 0, "R6 first poll immediate", gapb[2], 0);
        chk(gapb[3] == GAP, "R6 pause between polls", gapb[3], GAP);
        chk(gapb[4] == 0, "R6 attempt after idle", gapb[4], 0);

        // R7 quirk flag read
        prep(); stat[0] = 8'h01; stat[1] = 8'h01; stat[2] = 8'h00; stat[3] = 8'h02;
        ep(8'h06); ep(8'h05); ep(8'h05); ep(8'h05); ep(8'h70); ep(8'h06); ep(8'h05);
        go(1'b1, 0); verify("R7 quirk", 0);

        // R8 busy timeout
        prep(); for (int i = 0; i < 16; i++) stat[i] = 8'h01;
        ep(8'h06); for (int i = 0; i <= POLLS; i++) ep(8'h05);
        go(1'b0, 0); verify("R8 busy timeout", 2);
        chk(gapb[3] == GAP && gapb[4] == GAP, "R8 pauses", gapb[4], GAP);

        // R6 R5 wait counts as attempt
        prep();
        for (int i = 0; i < TRIES; i++) begin
            stat[2*i] = 8'h01; stat[2*i+1] = 8'h00;
            ep(8'h06); ep(8'h05); ep(8'h05);
        end
        go(1'b0, 0); verify("R6 R5 wait counted", 1);

        // R9 port error on status read and on write-enable
        prep(); err_at = 1; stat[0] = 8'h02; ep(8'h06); ep(8'h05);
        go(1'b0, 0); verify("R9 error on status", 3);
        prep(); err_at = 0; ep(8'h06);
        go(1'b0, 0); verify("R9 error on wren", 3);

        // R11 start ignored while running
        prep(); stat[0] = 8'h00; stat[1] = 8'h00; stat[2] = 8'h02;
        for (int i = 0; i < 3; i++) begin ep(8'h06); ep(8'h05); end
        go(1'b0, 3); verify("R11 restart ignored", 0);
        chk(!cmd_valid, "R11 idle after finish", cmd_valid, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule